// File: doc/BRIEF.md
# Interrupt-Gated Bus Stall Watchdog

This block watches a serial bus controller for a transaction that has stopped making progress. Whenever the controller's serial-interrupt flag is low, software owes the controller nothing, so the bus should be moving. A free-running counter measures how long that lasts. If the counter wraps before the flag is raised again, the block latches a sticky time-out flag and, if enabled, raises an interrupt request.

The count is cleared and held at zero whenever the interrupt flag is high or the watchdog is disabled. Counting therefore always measures one uninterrupted stretch of the flag being low. A slow option advances the count once every four clocks, which makes the time-out period four times longer. Software acknowledges a time-out with a one-cycle write-1-to-clear strobe. The bus state machine and the register file sit outside this block.

Top module: `bus_stall_watchdog`

## Requirements
- R1: While `tmo_en` is 1, `si_flag` is 0 and `slow_sel` is 0, the count advances on every clock edge. `tmo_flag` becomes 1 after exactly 2^CNT_W such edges (16384 at the default CNT_W of 14).
- R2: A clock edge that samples `si_flag` = 1 clears the count to zero. After `si_flag` returns to 0, a full 2^CNT_W edges are needed again before a time-out.
- R3: With `slow_sel` = 1, the count advances once every four running edges, so a time-out needs exactly 4 x 2^CNT_W edges of uninterrupted running.
- R4: A clock edge that samples `tmo_en` = 0 clears both the count and the slow-mode phase. It leaves `tmo_flag` unchanged, and no time-out can occur while the block is disabled.
- R5: `tmo_flag` is sticky. Once set, it stays 1 until it is cleared by `flag_clr`, whatever `si_flag` and `tmo_en` do.
- R6: After each clock edge, `tmo_irq` equals the new value of `tmo_flag` ANDed with the value of `irq_en` sampled at that edge.
- R7: An edge that samples `flag_clr` = 1, with no time-out at that same edge, clears `tmo_flag` to 0.
- R8: If a time-out and `flag_clr` = 1 fall on the same edge, `tmo_flag` is 1 after that edge. Setting wins over clearing.
- R9: At a time-out the count returns to zero and keeps running. The next time-out follows exactly 2^CNT_W running edges later (normal mode).
- R10: A synchronous active-high `rst` clears the count, the phase, `tmo_flag` and `tmo_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_en | input | 1 | Watchdog enable; 0 holds the count and phase at zero |
| slow_sel | input | 1 | 1 = count advances once every four clocks |
| si_flag | input | 1 | Serial-interrupt flag of the controller; 1 holds the count at zero |
| irq_en | input | 1 | Interrupt enable for the time-out request |
| flag_clr | input | 1 | One-cycle write-1-to-clear strobe for the time-out flag |
| tmo_flag | output | 1 | Sticky time-out flag (registered) |
| tmo_irq | output | 1 | Time-out interrupt request (registered) |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `rst` is held high from time zero until the first edges have passed, so no property is evaluated on pre-reset values. The bench changes inputs only on the falling edge and samples outputs there too. It shrinks the counter width to 12 so that normal-mode and slow-mode periods can both be walked edge by edge. It lines up a clear strobe with the exact wrap edge to test the set-over-clear priority.

// File: rtl/stall_wd_pkg.sv
package stall_wd_pkg;
  // ratio of the slow count mode
  localparam int unsigned SLOW_RATIO = 4;
  localparam int unsigned PHASE_W    = $clog2(SLOW_RATIO);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(SLOW_RATIO - 1);
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/stall_wd_prescale.sv
module stall_wd_prescale
  import stall_wd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow_sel,
  output logic tick
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
    end else if (slow_sel) begin
      phase_q <= (phase_q == PHASE_LAST) ? '0 : phase_q + 1'b1;
    end else begin
      phase_q <= '0;
    end
  end

  assign tick = run && (!slow_sel || phase_q == PHASE_LAST);

  // slow mode: a tick is never followed by another tick on the next edge
  assert_slow_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (run && slow_sel && tick) |=> !(tick && slow_sel));

  // a stopped prescaler restarts from phase zero
  assert_phase_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase_q == '0));
endmodule

// File: rtl/stall_wd_count.sv
module stall_wd_count #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic wrap
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wrap = tick && (&cnt_q);

  // held at zero while stopped (interrupt flag high or disabled)
  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  // without a tick the count does not move
  assert_no_step_R1: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));

  // a wrap leaves the count at zero
  assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/stall_wd_flag.sv
module stall_wd_flag (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_d;

  assign flag_d = wrap || (flag && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= flag_d && irq_en;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !wrap) |=> !flag);

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
endmodule

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic tmo_en,
  input  logic slow_sel,
  input  logic si_flag,
  input  logic irq_en,
  input  logic flag_clr,
  output logic tmo_flag,
  output logic tmo_irq
);
  logic run;
  logic tick;
  logic wrap;

  assign run = tmo_en && !si_flag;

  stall_wd_prescale u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .slow_sel (slow_sel),
    .tick     (tick)
  );

  stall_wd_count #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick),
    .wrap (wrap)
  );

  stall_wd_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .wrap   (wrap),
    .clr    (flag_clr),
    .irq_en (irq_en),
    .flag   (tmo_flag),
    .irq    (tmo_irq)
  );

  // reset leaves both outputs low
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!tmo_flag && !tmo_irq));
endmodule

// File: tb/bus_stall_watchdog_tb_top.sv
`timescale 1ns/1ps
module bus_stall_watchdog_tb_top;
  localparam int CNT_W = 12;
  localparam int N     = 2 ** CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmo_en = 1'b0, slow_sel = 1'b0, si_flag = 1'b1, irq_en = 1'b0, flag_clr = 1'b0;
  logic tmo_flag, tmo_irq;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bus_stall_watchdog #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .tmo_en(tmo_en), .slow_sel(slow_sel),
    .si_flag(si_flag), .irq_en(irq_en), .flag_clr(flag_clr),
    .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
  );

  // fields: si_flag, irq_en, flag_clr, expected flag, expected irq
  localparam logic [4:0] VEC [7] = '{
    5'b11011,   // R6 flag held, irq on
    5'b10010,   // R6 irq_en low masks request
    5'b11011,   // R6 request returns
    5'b11100,   // R7 write-1 clears
    5'b11000,   // R7 stays cleared
    5'b01000,   // R7 running, far from wrap
    5'b00100    // R7 clear on already-clear flag
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(8 * 200000);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    edges(3);
    chk("R10 flag in reset", tmo_flag, 1'b0);
    chk("R10 irq in reset", tmo_irq, 1'b0);
    rst = 1'b0;

    // R1 normal-mode period
    tmo_en = 1'b1; si_flag = 1'b0; irq_en = 1'b1;
    edges(N - 1);
    chk("R1 no flag one edge early", tmo_flag, 1'b0);
    edges(1);
    chk("R1 flag at period", tmo_flag, 1'b1);
    chk("R6 irq with enable", tmo_irq, 1'b1);

    // R9 wrap to zero, next period
    flag_clr = 1'b1;
    edges(1);
    flag_clr = 1'b0;
    chk("R7 cleared by strobe", tmo_flag, 1'b0);
    edges(N - 2);
    chk("R9 no second flag early", tmo_flag, 1'b0);
    edges(1);
    chk("R9 second flag after wrap", tmo_flag, 1'b1);

    // R2 interrupt flag restarts the count
    flag_clr = 1'b1;
    edges(1);
    flag_clr = 1'b0;
    edges(100);
    si_flag = 1'b1;
    edges(1);
    si_flag = 1'b0;
    edges(N - 1);
    chk("R2 restart needs full period", tmo_flag, 1'b0);
    edges(1);
    chk("R2 flag after full period", tmo_flag, 1'b1);

    // R5 sticky while counting stopped
    si_flag = 1'b1;
    edges(5);
    chk("R5 flag sticky", tmo_flag, 1'b1);

    // table walk: irq gating and clearing
    foreach (VEC[i]) begin
      si_flag = VEC[i][4]; irq_en = VEC[i][3]; flag_clr = VEC[i][2];
      edges(1);
      chk("R6 R7 table flag", tmo_flag, VEC[i][1]);
      chk("R6 R7 table irq", tmo_irq, VEC[i][0]);
    end
    flag_clr = 1'b0; irq_en = 1'b1;

    // R4 disabled block never times out
    tmo_en = 1'b0; si_flag = 1'b0;
    edges(N + 10);
    chk("R4 no time-out while disabled", tmo_flag, 1'b0);

    // R3/R4 slow mode, disable mid-way clears count and phase
    tmo_en = 1'b1; slow_sel = 1'b1;
    edges(23);
    tmo_en = 1'b0;
    edges(1);
    tmo_en = 1'b1;
    edges(4 * N - 1);
    chk("R3 R4 slow no flag early", tmo_flag, 1'b0);
    edges(1);
    chk("R3 slow flag at 4x period", tmo_flag, 1'b1);

    // R4 disable leaves flag unchanged
    tmo_en = 1'b0;
    edges(3);
    chk("R4 flag kept when disabled", tmo_flag, 1'b1);
    chk("R4 irq kept when disabled", tmo_irq, 1'b1);

    // R8 set beats clear on the wrap edge
    slow_sel = 1'b0; flag_clr = 1'b1;
    edges(1);
    flag_clr = 1'b0;
    chk("R7 clear before R8 test", tmo_flag, 1'b0);
    tmo_en = 1'b1;
    edges(N - 1);
    chk("R8 no flag before wrap", tmo_flag, 1'b0);
    flag_clr = 1'b1;
    edges(1);
    flag_clr = 1'b0;
    chk("R8 set wins over clear", tmo_flag, 1'b1);

    summary();
    $finish;
  end
endmodule